// File: doc/BRIEF.md
# Interrupt Response Cycle Sequencer

This block drives the bus activity that an 8-bit processor core performs once it has decided to take an interrupt. The core issues a single-clock start pulse marked as either non-maskable or maskable, and supplies the current interrupt mode, program counter, stack pointer and interrupt page register. The sequencer then steps through the response machine cycles, one clock per T-state. It raises opcode-cycle, acknowledge, read and write strobes together with the address and write data. It samples the 8-bit data bus where a byte must be taken in, and moves the stack pointer down before each push. At the end it presents the address where execution resumes.

Each response kind has its own cycle shape. The non-maskable response opens with a five-T-state opcode read of the current PC. Every maskable response opens with a seven-T-state acknowledge cycle, which is a four-T-state opcode cycle widened by two automatic wait states and one more T-state for the stack pointer. The rest of the order depends on the mode. Mode 1 pushes and then jumps to a fixed address. Mode 2 pushes first and then fetches a vector. Mode 0 reads the byte given during acknowledge: a restart byte leads to a push and a jump, while a call byte leads to two operand reads before the push. One clock after the final T-state a done pulse is raised, and a start pulse that arrives while a response is running is dropped.

Top module: `irq_resp_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `m1_o`, `ack_o`, `rd_o` and `wr_o` are low, and `sp_o` and `new_pc_o` read 0.
- R2: A non-maskable start (`nmi_i`=1) runs 11 T-states in cycles of 5, 3 and 3. The first cycle has `m1_o` and `rd_o` high with `addr_o` equal to the PC and `ack_o` low. The two pushes follow, and the resume address is 0x0066.
- R3: A maskable start in mode 1 (`mode_i`=1) runs 13 T-states in cycles of 7, 3 and 3: acknowledge, push high, push low. The resume address is 0x0038.
- R4: In mode 0 (`mode_i`=0), any acknowledge byte other than 0xCD is taken as a restart: 13 T-states in cycles of 7, 3 and 3. The resume address is zero except for bits 5:3, which are copied from that byte (0x0000 to 0x0038 in steps of 8).
- R5: In mode 0 with acknowledge byte 0xCD the response runs 19 T-states in cycles of 7, 3, 3, 3 and 3. Two reads come first, at the PC and at PC+1, and give the low and then the high byte of the resume address. The two pushes follow.
- R6: In mode 2 (`mode_i`=2, and also for `mode_i`=3) the response runs 19 T-states in cycles of 7, 3, 3, 3 and 3. The acknowledge cycle and the two pushes come first. Then come reads at {`ireg_i`, acknowledge byte} and at that address plus 1, carrying into the high byte, which give the low and then the high byte of the resume address.
- R7: The stack pointer falls by one in the clock edge that ends the cycle before each push. `sp_o` holds the start value through the acknowledge or fetch cycle and any operand reads. The high PC byte is written at SP-1 and the low byte at SP-2, with 16-bit wraparound, and `addr_o` equals `sp_o` during a write.
- R8: During all seven acknowledge T-states both `m1_o` and `ack_o` are high and `addr_o` shows the PC. Every byte taken from `data_i` is sampled on the edge that ends the last T-state of its cycle.
- R9: `done_o` is high with `busy_o` for exactly one clock after the last T-state, with `new_pc_o` then holding the resume address; the next clock is idle.
- R10: A start pulse is ignored while `busy_o` is high, including the done clock; a start held high is taken on the first idle clock.
- R11: `rd_o` and `wr_o` are never high together, and no strobe is high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a response (taken only when idle) |
| nmi_i | input | 1 | 1: non-maskable response, 0: maskable |
| mode_i | input | 2 | Interrupt mode 0..3 (3 behaves as 2) |
| pc_i | input | 16 | PC to save |
| sp_i | input | 16 | Stack pointer at start |
| ireg_i | input | 8 | Interrupt page register |
| data_i | input | 8 | Data bus input |
| busy_o | output | 1 | Response in progress, done clock included |
| m1_o | output | 1 | Opcode-style first cycle |
| ack_o | output | 1 | Interrupt acknowledge cycle |
| rd_o | output | 1 | Read cycle |
| wr_o | output | 1 | Stack write cycle |
| addr_o | output | 16 | Bus address |
| wdata_o | output | 8 | Write data |
| sp_o | output | 16 | Current stack pointer |
| new_pc_o | output | 16 | Resume address |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The assertions assume that reset is applied at the start and that `mode_i`, `nmi_i` and the register inputs matter only in the clock where a start is taken. They also assume that `data_i` is valid on the edge ending each sampling T-state. The bench changes `data_i` only on falling edges. It drives the data bus from a deterministic function of `addr_o`, and from the chosen acknowledge byte whenever `ack_o` is high. It holds `start_i` high across running responses and across the done clock, so the model's acceptance rule is what decides when the next response begins.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_FETCH,
      PH_ACK,
      PH_PUSH_HI,
      PH_PUSH_LO,
      PH_OPND_LO,
      PH_OPND_HI,
      PH_VEC_LO,
      PH_VEC_HI,
      PH_DONE
   } phase_e;

   function automatic logic is_push(phase_e p);
      return (p == PH_PUSH_HI) || (p == PH_PUSH_LO);
   endfunction

   function automatic logic is_read(phase_e p);
      return (p == PH_FETCH) || (p == PH_OPND_LO) || (p == PH_OPND_HI) ||
             (p == PH_VEC_LO) || (p == PH_VEC_HI);
   endfunction

endpackage

// File: rtl/irq_seq_step.sv
module irq_seq_step
   import irq_seq_pkg::*;
#(
   parameter int OPF_T     = 4,
   parameter int NMI_EXTRA = 1,
   parameter int ACK_WAITS = 2,
   parameter int ACK_EXTRA = 1,
   parameter int MEM_T     = 3,
   parameter int CW        = 3
) (
   input  phase_e          ph_i,
   input  logic            nmi_i,
   input  logic [1:0]      mode_i,
   input  logic            call_i,
   output phase_e          nxt_o,
   output logic [CW-1:0]   len_o
);
   localparam int FETCH_LEN = OPF_T + NMI_EXTRA;
   localparam int ACK_LEN   = OPF_T + ACK_WAITS + ACK_EXTRA;

   always_comb begin
      nxt_o = PH_IDLE;
      unique case (ph_i)
         PH_FETCH:   nxt_o = PH_PUSH_HI;
         PH_ACK:     nxt_o = (mode_i == 2'd0 && call_i) ? PH_OPND_LO : PH_PUSH_HI;
         PH_OPND_LO: nxt_o = PH_OPND_HI;
         PH_OPND_HI: nxt_o = PH_PUSH_HI;
         PH_PUSH_HI: nxt_o = PH_PUSH_LO;
         PH_PUSH_LO: nxt_o = (!nmi_i && mode_i == 2'd2) ? PH_VEC_LO : PH_DONE;
         PH_VEC_LO:  nxt_o = PH_VEC_HI;
         PH_VEC_HI:  nxt_o = PH_DONE;
         default:    nxt_o = PH_IDLE;
      endcase
   end

   always_comb begin
      unique case (ph_i)
         PH_FETCH:                         len_o = CW'(FETCH_LEN);
         PH_ACK:                           len_o = CW'(ACK_LEN);
         PH_PUSH_HI, PH_PUSH_LO,
         PH_OPND_LO, PH_OPND_HI,
         PH_VEC_LO, PH_VEC_HI:             len_o = CW'(MEM_T);
         default:                          len_o = CW'(1);
      endcase
   end

endmodule

// File: rtl/irq_seq_tcount.sv
module irq_seq_tcount #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          run_i,
   input  logic [CW-1:0] len_i,
   output logic          last_o
);
   logic [CW-1:0] cnt_q;

   assign last_o = run_i && (cnt_q == len_i - CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || last_o) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs
   import irq_seq_pkg::*;
#(
   parameter int          DW         = 8,
   parameter int          AW         = 16,
   parameter logic [15:0] NMI_TARGET = 16'h0066,
   parameter logic [15:0] IM1_TARGET = 16'h0038,
   parameter logic [7:0]  CALL_OPC   = 8'hCD
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] sp_i,
   input  logic [DW-1:0] ireg_i,
   input  logic          nmi_i,
   input  logic [1:0]    mode_i,
   input  logic          adv_i,
   input  phase_e        ph_i,
   input  phase_e        nxt_i,
   input  logic [DW-1:0] data_i,
   output logic [AW-1:0] pc_q,
   output logic [AW-1:0] sp_q,
   output logic [DW-1:0] ireg_q,
   output logic [DW-1:0] opc_q,
   output logic          nmi_q,
   output logic [1:0]    mode_q,
   output logic [AW-1:0] newpc_q
);
   logic [DW-1:0] lo_q, hi_q;
   logic [AW-1:0] target;

   always_comb begin
      if (ph_i == PH_VEC_HI)
         target = {data_i, lo_q};
      else if (nmi_q)
         target = AW'(NMI_TARGET);
      else if (mode_q == 2'd1)
         target = AW'(IM1_TARGET);
      else if (opc_q == DW'(CALL_OPC))
         target = {hi_q, lo_q};
      else
         target = {{(AW-6){1'b0}}, opc_q[5:3], 3'b000};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q    <= '0;
         sp_q    <= '0;
         ireg_q  <= '0;
         opc_q   <= '0;
         nmi_q   <= 1'b0;
         mode_q  <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         newpc_q <= '0;
      end else if (load_i) begin
         pc_q   <= pc_i;
         sp_q   <= sp_i;
         ireg_q <= ireg_i;
         nmi_q  <= nmi_i;
         mode_q <= mode_i;
      end else if (adv_i) begin
         if (is_push(nxt_i))
            sp_q <= sp_q - AW'(1);
         case (ph_i)
            PH_ACK:                lo_q <= lo_q;
            PH_OPND_LO, PH_VEC_LO: lo_q <= data_i;
            PH_OPND_HI:            hi_q <= data_i;
            default:               hi_q <= hi_q;
         endcase
         if (ph_i == PH_ACK)
            opc_q <= data_i;
         if (nxt_i == PH_DONE)
            newpc_q <= target;
      end
   end

endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
   import irq_seq_pkg::*;
#(
   parameter int          DW            = 8,
   parameter int          OPF_T         = 4,
   parameter int          NMI_EXTRA     = 1,
   parameter int          ACK_WAITS     = 2,
   parameter int          ACK_EXTRA     = 1,
   parameter int          MEM_T         = 3,
   parameter logic [15:0] NMI_TARGET    = 16'h0066,
   parameter logic [15:0] IM1_TARGET    = 16'h0038,
   parameter logic [7:0]  CALL_OPC      = 8'hCD,
   parameter bit          MODE3_AS_IM2  = 1'b1,
   localparam int         AW            = 2 * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          nmi_i,
   input  logic [1:0]    mode_i,
   input  logic [AW-1:0] pc_i,
   input  logic [AW-1:0] sp_i,
   input  logic [DW-1:0] ireg_i,
   input  logic [DW-1:0] data_i,
   output logic          busy_o,
   output logic          m1_o,
   output logic          ack_o,
   output logic          rd_o,
   output logic          wr_o,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] wdata_o,
   output logic [AW-1:0] sp_o,
   output logic [AW-1:0] new_pc_o,
   output logic          done_o
);
   localparam int FETCH_LEN = OPF_T + NMI_EXTRA;
   localparam int ACK_LEN   = OPF_T + ACK_WAITS + ACK_EXTRA;
   localparam int MAX_A     = (FETCH_LEN > ACK_LEN) ? FETCH_LEN : ACK_LEN;
   localparam int MAX_LEN   = (MAX_A > MEM_T) ? MAX_A : MEM_T;
   localparam int CW        = $clog2(MAX_LEN + 1);

   if (DW < 4)            begin : g_bad_dw   $error("DW must be at least 4");          end
   if (OPF_T < 1)         begin : g_bad_opf  $error("OPF_T must be positive");         end
   if (MEM_T < 1)         begin : g_bad_mem  $error("MEM_T must be positive");         end
   if (ACK_WAITS < 0)     begin : g_bad_wait $error("ACK_WAITS must not be negative"); end

   phase_e        ph_q, nxt;
   logic [CW-1:0] len;
   logic          tlast, accept, adv, call_now;
   logic [1:0]    mode_map;
   logic [AW-1:0] pc_q, sp_q, newpc_q;
   logic [DW-1:0] ireg_q, opc_q;
   logic          nmi_q;
   logic [1:0]    mode_q;
   logic [AW-1:0] vec_addr;

   if (MODE3_AS_IM2) begin : g_m3_vec
      assign mode_map = (mode_i == 2'd3) ? 2'd2 : mode_i;
   end else begin : g_m3_fix
      assign mode_map = (mode_i == 2'd3) ? 2'd1 : mode_i;
   end

   assign accept   = start_i && (ph_q == PH_IDLE);
   assign adv      = (ph_q != PH_IDLE) && tlast;
   assign call_now = (ph_q == PH_ACK) ? (data_i == CALL_OPC) : (opc_q == CALL_OPC);
   assign vec_addr = {ireg_q, opc_q};

   irq_seq_step #(
      .OPF_T(OPF_T), .NMI_EXTRA(NMI_EXTRA), .ACK_WAITS(ACK_WAITS),
      .ACK_EXTRA(ACK_EXTRA), .MEM_T(MEM_T), .CW(CW)
   ) u_step (
      .ph_i(ph_q), .nmi_i(nmi_q), .mode_i(mode_q), .call_i(call_now),
      .nxt_o(nxt), .len_o(len)
   );

   irq_seq_tcount #(.CW(CW)) u_tcnt (
      .clk(clk), .rst_n(rst_n), .clr_i(accept), .run_i(ph_q != PH_IDLE),
      .len_i(len), .last_o(tlast)
   );

   irq_seq_regs #(
      .DW(DW), .AW(AW), .NMI_TARGET(NMI_TARGET), .IM1_TARGET(IM1_TARGET),
      .CALL_OPC(CALL_OPC)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .load_i(accept), .pc_i(pc_i), .sp_i(sp_i),
      .ireg_i(ireg_i), .nmi_i(nmi_i), .mode_i(mode_map), .adv_i(adv),
      .ph_i(ph_q), .nxt_i(nxt), .data_i(data_i), .pc_q(pc_q), .sp_q(sp_q),
      .ireg_q(ireg_q), .opc_q(opc_q), .nmi_q(nmi_q), .mode_q(mode_q),
      .newpc_q(newpc_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ph_q <= PH_IDLE;
      else if (accept)
         ph_q <= nmi_i ? PH_FETCH : PH_ACK;
      else if (adv)
         ph_q <= nxt;
   end

   always_comb begin
      unique case (ph_q)
         PH_FETCH, PH_ACK, PH_OPND_LO: addr_o = pc_q;
         PH_OPND_HI:                   addr_o = pc_q + AW'(1);
         PH_PUSH_HI, PH_PUSH_LO:       addr_o = sp_q;
         PH_VEC_LO:                    addr_o = vec_addr;
         PH_VEC_HI:                    addr_o = vec_addr + AW'(1);
         default:                      addr_o = '0;
      endcase
   end

   always_comb begin
      unique case (ph_q)
         PH_PUSH_HI: wdata_o = pc_q[AW-1:DW];
         PH_PUSH_LO: wdata_o = pc_q[DW-1:0];
         default:    wdata_o = '0;
      endcase
   end

   assign busy_o   = (ph_q != PH_IDLE);
   assign m1_o     = (ph_q == PH_FETCH) || (ph_q == PH_ACK);
   assign ack_o    = (ph_q == PH_ACK);
   assign rd_o     = is_read(ph_q);
   assign wr_o     = is_push(ph_q);
   assign done_o   = (ph_q == PH_DONE);
   assign sp_o     = sp_q;
   assign new_pc_o = newpc_q;

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy_o,
   input logic          m1_o,
   input logic          ack_o,
   input logic          rd_o,
   input logic          wr_o,
   input logic          done_o,
   input logic [AW-1:0] addr_o,
   input logic [AW-1:0] sp_o
);
   AST_ACK_IN_M1: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> m1_o);                                              // R8
   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_o && wr_o));                                             // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !(m1_o || ack_o || rd_o || wr_o || done_o));      // R11
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));                             // R9
   AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_o) |-> (sp_o == $past(sp_o) - AW'(1)));              // R7
   AST_WR_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> (addr_o == sp_o));                                   // R7
   AST_OPEN_M1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> m1_o);                                      // R8
   AST_STAY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);                              // R10
endmodule

bind irq_resp_seq irq_seq_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .m1_o(m1_o), .ack_o(ack_o),
   .rd_o(rd_o), .wr_o(wr_o), .done_o(done_o), .addr_o(addr_o), .sp_o(sp_o)
);

// File: tb/tb_irq_resp_seq.sv
module tb_irq_resp_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, nmi_i = 1'b0;
   logic [1:0]  mode_i = '0;
   logic [15:0] pc_i = '0, sp_i = '0;
   logic [7:0]  ireg_i = '0, data_i = '0, ack_byte = '0, run_ack = '0;
   logic        busy_o, m1_o, ack_o, rd_o, wr_o, done_o;
   logic [15:0] addr_o, sp_o, new_pc_o;
   logic [7:0]  wdata_o;

   always #2 clk = ~clk;   // 250 MHz

   irq_resp_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .nmi_i(nmi_i), .mode_i(mode_i),
      .pc_i(pc_i), .sp_i(sp_i), .ireg_i(ireg_i), .data_i(data_i),
      .busy_o(busy_o), .m1_o(m1_o), .ack_o(ack_o), .rd_o(rd_o), .wr_o(wr_o),
      .addr_o(addr_o), .wdata_o(wdata_o), .sp_o(sp_o), .new_pc_o(new_pc_o),
      .done_o(done_o)
   );

   typedef struct packed {
      logic        m1, ack, rd, wr, done;
      logic [15:0] addr;
      logic [7:0]  wd;
      logic [15:0] sp;
      logic [15:0] npc;
   } ent_t;

   ent_t  exp_q[$];
   string tag_q[$];
   int    n_chk = 0, n_bad = 0, cycles = 0;
   bit    last_busy = 0;

   function automatic logic [7:0] memf(logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
   endfunction

   task automatic add(int n, bit m1, bit ak, bit rd, bit wr, logic [15:0] a,
                      logic [7:0] w, logic [15:0] s, string t);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back('{m1: m1, ack: ak, rd: rd, wr: wr, done: 1'b0,
                           addr: a, wd: w, sp: s, npc: 16'h0});
         tag_q.push_back(t);
      end
   endtask

   task automatic build(bit nmi, logic [1:0] mode, logic [15:0] pc, logic [15:0] sp,
                        logic [7:0] ir, logic [7:0] ab);
      logic [15:0] s, tgt, v;
      s = sp;
      run_ack = ab;
      if (nmi) begin
         add(5, 1, 0, 1, 0, pc, 8'h00, s, "R2");
         tgt = 16'h0066;                                       // R2
      end else begin
         add(7, 1, 1, 0, 0, pc, 8'h00, s, "R8");
         tgt = 16'h0;
         if (mode == 2'd0 && ab == 8'hCD) begin
            add(3, 0, 0, 1, 0, pc, 8'h00, s, "R5");
            add(3, 0, 0, 1, 0, pc + 16'd1, 8'h00, s, "R5");
            tgt = {memf(pc + 16'd1), memf(pc)};
         end else if (mode == 2'd1) tgt = 16'h0038;            // R3
         else if (mode == 2'd0) tgt = {10'b0, ab[5:3], 3'b000}; // R4
      end
      s = s - 16'd1;
      add(3, 0, 0, 0, 1, s, pc[15:8], s, "R7");
      s = s - 16'd1;
      add(3, 0, 0, 0, 1, s, pc[7:0], s, "R7");
      if (!nmi && mode >= 2'd2) begin
         v = {ir, ab};
         add(3, 0, 0, 1, 0, v, 8'h00, s, "R6");
         add(3, 0, 0, 1, 0, v + 16'd1, 8'h00, s, "R6");
         tgt = {memf(v + 16'd1), memf(v)};
      end
      exp_q.push_back('{m1: 0, ack: 0, rd: 0, wr: 0, done: 1'b1, addr: 16'h0,
                        wd: 8'h0, sp: s, npc: tgt});
      tag_q.push_back("R9");
   endtask

   task automatic fail(string t, string what, logic [15:0] act, logic [15:0] ex);
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, ex);
   endtask

   task automatic compare();
      bit bad = 0;
      n_chk++;
      if (exp_q.size() != 0) begin
         ent_t  e = exp_q.pop_front();
         string t = tag_q.pop_front();
         if (busy_o !== 1'b1) begin bad = 1; fail(t, "busy", 16'(busy_o), 16'h1); end
         if (m1_o !== e.m1)   begin bad = 1; fail(t, "m1", 16'(m1_o), 16'(e.m1)); end
         if (ack_o !== e.ack) begin bad = 1; fail(t, "ack", 16'(ack_o), 16'(e.ack)); end
         if (rd_o !== e.rd)   begin bad = 1; fail(t, "rd", 16'(rd_o), 16'(e.rd)); end
         if (wr_o !== e.wr)   begin bad = 1; fail(t, "wr", 16'(wr_o), 16'(e.wr)); end
         if (done_o !== e.done) begin bad = 1; fail(t, "done", 16'(done_o), 16'(e.done)); end
         if ((e.m1 || e.rd || e.wr) && addr_o !== e.addr)
            begin bad = 1; fail(t, "addr", addr_o, e.addr); end
         if (e.wr && wdata_o !== e.wd) begin bad = 1; fail(t, "wdata", 16'(wdata_o), 16'(e.wd)); end
         if (sp_o !== e.sp) begin bad = 1; fail(t, "sp", sp_o, e.sp); end
         if (e.done && new_pc_o !== e.npc) begin bad = 1; fail(t, "new_pc", new_pc_o, e.npc); end
         last_busy = 1;
      end else begin
         // R11: idle means no strobe at all
         if ({busy_o, m1_o, ack_o, rd_o, wr_o, done_o} !== 6'b0) begin
            bad = 1;
            fail("R11", "idle strobes", 16'({busy_o, m1_o, ack_o, rd_o, wr_o, done_o}), 16'h0);
         end
         last_busy = 0;
      end
      if (bad) n_bad++;
   endtask

   task automatic step();
      @(negedge clk);
      compare();
      data_i = ack_o ? run_ack : (rd_o ? memf(addr_o) : 8'h00);
   endtask

   // R10: model takes a start only when its queue is empty and the last clock was idle
   task automatic try_accept();
      if (start_i && exp_q.size() == 0 && !last_busy)
         build(nmi_i, mode_i, pc_i, sp_i, ireg_i, ack_byte);
   endtask

   task automatic fire(bit nmi, logic [1:0] mode, logic [15:0] pc, logic [15:0] sp,
                       logic [7:0] ir, logic [7:0] ab);
      nmi_i = nmi; mode_i = mode; pc_i = pc; sp_i = sp; ireg_i = ir; ack_byte = ab;
      start_i = 1'b1;
      try_accept();
      step();
      start_i = 1'b0;
      while (exp_q.size() != 0) step();
      step();
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cycles, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) step();
      // R1: reset values of the visible registers
      n_chk++;
      if (sp_o !== 16'h0 || new_pc_o !== 16'h0) begin
         n_bad++;
         fail("R1", "sp/new_pc", sp_o | new_pc_o, 16'h0);
      end
      fire(1, 2'd1, 16'h1234, 16'h8000, 8'h00, 8'hFF);   // R2
      fire(0, 2'd1, 16'hABCD, 16'h0002, 8'h00, 8'hFF);   // R3
      fire(0, 2'd1, 16'h00FE, 16'h0001, 8'h00, 8'h00);   // R7 wrap
      fire(0, 2'd0, 16'h4321, 16'hC000, 8'h00, 8'hEF);   // R4 -> 0x0028
      fire(0, 2'd0, 16'h4321, 16'hC000, 8'h00, 8'hC7);   // R4 -> 0x0000
      fire(0, 2'd0, 16'h0100, 16'hC000, 8'h00, 8'hFF);   // R4 -> 0x0038
      fire(0, 2'd0, 16'h5A5A, 16'hF000, 8'h00, 8'hCD);   // R5
      fire(0, 2'd2, 16'h2468, 16'hE000, 8'h40, 8'hFE);   // R6
      fire(0, 2'd2, 16'h1357, 16'hE000, 8'h12, 8'hFF);   // R6 carry
      fire(0, 2'd3, 16'h7777, 16'hD000, 8'h33, 8'h10);   // R6 mode 3
      fire(1, 2'd2, 16'hFFFF, 16'h0000, 8'h55, 8'hCD);   // R2 mode ignored
      // R10: start held through a running response and its done clock
      nmi_i = 1'b1; mode_i = 2'd0; pc_i = 16'h0F0F; sp_i = 16'h9000;
      ireg_i = 8'h00; ack_byte = 8'hEF; start_i = 1'b1;
      try_accept();
      for (int k = 0; k < 20; k++) begin
         step();
         nmi_i = 1'b0; mode_i = 2'd1; pc_i = 16'h3C3C + 16'(k);
         try_accept();
      end
      start_i = 1'b0;
      while (exp_q.size() != 0) step();
      repeat (2) step();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule